// File: doc/BRIEF.md
# Encoded Wait-State Bus Cycle Timer

This block times external bus accesses for a set of memory areas (two by default). Each area carries a 4-bit wait code and a flag that puts the area in PC-card mode. The code is decoded through a nonlinear table. The table gives the number of wait states inserted into the first (top) transfer of an access and the number of states taken by each following burst beat. The block also decides, state by state, whether the external WAIT input may stretch the transfer in progress.

An access begins when `start_i` is high while the timer is idle. At that point the area select, the burst length and the selected area's effective code are captured. The timer then runs the top transfer, followed by `burst_len_i` burst beats. It emits one single-cycle ready pulse per completed transfer, and a done pulse together with the last ready pulse. After that it returns to idle. Address and data paths, strobe shaping and bus arbitration are handled elsewhere.

Top module: `wait_state_timer`

## Requirements
- R1: With WAIT low, the top transfer inserts W wait states for effective code c, where W is c for c in 0..4, 2c-4 for c in 5..9 and 4c-22 for c in 10..15. Its ready pulse appears W+2 clock edges after the edge that accepted start (the accepting edge counts as edge 1).
- R2: When the effective code is 0, WAIT has no effect on the top transfer, whose ready pulse appears at edge 2.
- R3: When the effective code is nonzero, WAIT is sampled in the final state of the top transfer. Each edge at which it is high adds one state, so the ready pulse appears at the later of edge W+2 and the edge after WAIT is last seen high.
- R4: With WAIT low, each burst beat takes S states, where S is 2 for code 0 and W+1 for every other code. Each beat's ready pulse comes S edges after the previous ready pulse.
- R5: WAIT is honoured in every burst beat for every code, including code 0. It extends the beat one state per edge at which it is sampled high in the beat's final state.
- R6: Area k takes its code from bits [4k+3:4k] of `area_code_i` and its mode from bit k of `area_card_i`. The area selected at start governs the whole access, even if the select changes later.
- R7: The high bit of an area's code is used only when that area's PC-card bit is 1. Otherwise it is treated as 0.
- R8: An access gives exactly `burst_len_i`+1 single-cycle ready pulses (length captured at start). `done_o` pulses together with the last of them, and at that same point `busy_o` falls.
- R9: `start_i` has no effect while `busy_o` is high. Changes to the select or the length during an access do not alter its timing or its pulse count.
- R10: During and after reset, `ready_o`, `done_o` and `busy_o` are low. `busy_o` rises only on an edge at which start was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| area_code_i | input | 4*NUM_AREAS | Per-area 4-bit wait codes, area k at [4k+3:4k] |
| area_card_i | input | NUM_AREAS | Per-area PC-card mode flag |
| start_i | input | 1 | Access request, accepted only when idle |
| area_sel_i | input | AREA_W | Area of the requested access |
| burst_len_i | input | LEN_W | Number of burst beats after the top transfer |
| wait_i | input | 1 | External WAIT, high stretches the current transfer |
| ready_o | output | 1 | One-cycle pulse per completed transfer |
| done_o | output | 1 | One-cycle pulse with the last ready of an access |
| busy_o | output | 1 | Access in progress |

## Verification
The checker watches the pulse discipline on every cycle. Ready pulses never fall on back-to-back cycles, done always coincides with ready and with the drop of busy, and busy rises only after an accepted start. The table values, the code-0 exemption from WAIT in the top transfer alone, the PC-card gating of the high bit, and the capture of select and length can only be shown by the bench's scenarios. These compare every ready pulse's edge number against times computed from the code tables and the WAIT window.

// File: rtl/wst_pkg.sv
package wst_pkg;
  localparam int CODE_W = 4;
  localparam int CNT_W  = 6;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TOP  = 2'd1,
    ST_BEAT = 2'd2
  } wst_state_e;
endpackage

// File: rtl/wst_area_cfg.sv
module wst_area_cfg
  import wst_pkg::*;
#(
  parameter int AREA_W    = 1,
  parameter int NUM_AREAS = 2
) (
  input  logic [CODE_W*NUM_AREAS-1:0] area_code_i,
  input  logic [NUM_AREAS-1:0]        area_card_i,
  input  logic [AREA_W-1:0]           area_sel_i,
  output logic [CODE_W-1:0]           eff_code_o
);
  logic [CODE_W-1:0] eff_code [NUM_AREAS];

  // high code bit only counts in PC-card mode
  for (genvar k = 0; k < NUM_AREAS; k++) begin : g_area
    assign eff_code[k] = {area_code_i[CODE_W*k+CODE_W-1] & area_card_i[k],
                          area_code_i[CODE_W*k +: CODE_W-1]};
  end

  assign eff_code_o = eff_code[area_sel_i];
endmodule

// File: rtl/wst_code_decode.sv
module wst_code_decode
  import wst_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output logic [CNT_W-1:0]  top_waits_o,
  output logic [CNT_W-1:0]  beat_last_o
);
  // piecewise-linear: step 1 up to 4, step 2 up to 9, step 4 beyond
  always_comb begin
    logic [CNT_W-1:0] c;
    c = CNT_W'(code_i);
    if (code_i <= 4'd4)      top_waits_o = c;
    else if (code_i <= 4'd9) top_waits_o = (c << 1) - CNT_W'(4);
    else                     top_waits_o = (c << 2) - CNT_W'(22);
  end

  // beat states minus one: code 0 takes 2 states, others waits+1
  assign beat_last_o = (code_i == '0) ? CNT_W'(1) : top_waits_o;
endmodule

// File: rtl/wst_seq.sv
module wst_seq
  import wst_pkg::*;
#(
  parameter int LEN_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [CNT_W-1:0]  top_waits_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [CNT_W-1:0]  beat_last_i,
  input  logic              wait_i,
  output logic [CODE_W-1:0] code_q_o,
  output logic              ready_o,
  output logic              done_o,
  output logic              busy_o
);
  wst_state_e        st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [LEN_W-1:0]  beats_q;
  logic [CODE_W-1:0] code_q;
  logic              ready_q, done_q;
  logic              hold;

  // top transfer with code 0 ignores WAIT; beats always honour it
  assign hold = wait_i && ((st_q == ST_BEAT) || (code_q != '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      beats_q <= '0;
      code_q  <= '0;
      ready_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      ready_q <= 1'b0;
      done_q  <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            st_q    <= ST_TOP;
            cnt_q   <= top_waits_i;
            beats_q <= len_i;
            code_q  <= code_i;
          end
        end
        ST_TOP, ST_BEAT: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
          end else if (!hold) begin
            ready_q <= 1'b1;
            if (beats_q == '0) begin
              st_q   <= ST_IDLE;
              done_q <= 1'b1;
            end else begin
              beats_q <= beats_q - LEN_W'(1);
              st_q    <= ST_BEAT;
              cnt_q   <= beat_last_i;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign code_q_o = code_q;
  assign ready_o  = ready_q;
  assign done_o   = done_q;
  assign busy_o   = (st_q != ST_IDLE);
endmodule

// File: rtl/wait_state_timer.sv
module wait_state_timer
  import wst_pkg::*;
#(
  parameter int AREA_W = 1,
  parameter int LEN_W  = 3,
  localparam int NUM_AREAS = 1 << AREA_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [CODE_W*NUM_AREAS-1:0] area_code_i,
  input  logic [NUM_AREAS-1:0]        area_card_i,
  input  logic                        start_i,
  input  logic [AREA_W-1:0]           area_sel_i,
  input  logic [LEN_W-1:0]            burst_len_i,
  input  logic                        wait_i,
  output logic                        ready_o,
  output logic                        done_o,
  output logic                        busy_o
);
  logic [CODE_W-1:0] eff_code, code_q;
  logic [CNT_W-1:0]  top_waits, beat_last, unused_waits, unused_last;

  wst_area_cfg #(.AREA_W(AREA_W), .NUM_AREAS(NUM_AREAS)) u_cfg (
    .area_code_i(area_code_i),
    .area_card_i(area_card_i),
    .area_sel_i (area_sel_i),
    .eff_code_o (eff_code)
  );

  // live decode loads the top count; captured decode drives the beats
  wst_code_decode u_dec_live (
    .code_i     (eff_code),
    .top_waits_o(top_waits),
    .beat_last_o(unused_last)
  );

  wst_code_decode u_dec_held (
    .code_i     (code_q),
    .top_waits_o(unused_waits),
    .beat_last_o(beat_last)
  );

  wst_seq #(.LEN_W(LEN_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .code_i     (eff_code),
    .top_waits_i(top_waits),
    .len_i      (burst_len_i),
    .beat_last_i(beat_last),
    .wait_i     (wait_i),
    .code_q_o   (code_q),
    .ready_o    (ready_o),
    .done_o     (done_o),
    .busy_o     (busy_o)
  );

  logic unused_ok;
  assign unused_ok = ^{unused_waits, unused_last};
endmodule

// File: rtl/wst_checker.sv
module wst_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic ready_o,
  input logic done_o,
  input logic busy_o
);
  p_ready_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);

  p_done_on_ready_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ready_o);

  p_done_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_busy_end_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  p_busy_start_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  p_ready_in_access_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !done_o) |-> busy_o);
endmodule

bind wait_state_timer wst_checker u_wst_checker (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .ready_o(ready_o),
  .done_o (done_o),
  .busy_o (busy_o)
);

// File: tb/wait_state_timer_tb_top.sv
`timescale 1ns/1ps
module wait_state_timer_tb_top;
  localparam int AREA_W = 1;
  localparam int LEN_W  = 3;
  localparam int NA     = 1 << AREA_W;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [4*NA-1:0]   area_code_i = '0;
  logic [NA-1:0]     area_card_i = '0;
  logic              start_i = 1'b0;
  logic [AREA_W-1:0] area_sel_i = '0;
  logic [LEN_W-1:0]  burst_len_i = '0;
  logic              wait_i = 1'b0;
  logic              ready_o, done_o, busy_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk_i = ~clk_i;

  wait_state_timer #(.AREA_W(AREA_W), .LEN_W(LEN_W)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .area_code_i(area_code_i),
    .area_card_i(area_card_i), .start_i(start_i), .area_sel_i(area_sel_i),
    .burst_len_i(burst_len_i), .wait_i(wait_i), .ready_o(ready_o),
    .done_o(done_o), .busy_o(busy_o)
  );

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: act %0d cycles exp < 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic int f_waits(int c);
    case (c)
      0: return 0;   1: return 1;   2: return 2;   3: return 3;
      4: return 4;   5: return 6;   6: return 8;   7: return 10;
      8: return 12;  9: return 14;  10: return 18; 11: return 22;
      12: return 26; 13: return 30; 14: return 34; default: return 38;
    endcase
  endfunction

  function automatic int f_states(int c);
    case (c)
      0: return 2;   1: return 2;   2: return 3;   3: return 4;
      4: return 5;   5: return 7;   6: return 9;   7: return 11;
      8: return 13;  9: return 15;  10: return 19; 11: return 23;
      12: return 27; 13: return 31; 14: return 35; default: return 39;
    endcase
  endfunction

  function automatic int f_eff(int sel);
    int c;
    c = int'(area_code_i[4*sel +: 4]);
    if (!area_card_i[sel]) c = c & 7;
    return c;
  endfunction

  function automatic int f_max(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act %0d exp %0d", req, act, exp);
    end
  endtask

  // one access; WAIT high at edges 1..hw; optional disturbance at edge 2
  task automatic run_xfer(int sel, int len, int hw, bit inject, string req);
    int exp_t[8];
    int c, n, idx, last;
    c = f_eff(sel);
    exp_t[0] = (c == 0) ? 2 : f_max(f_waits(c) + 2, hw + 1);
    for (int j = 1; j <= len; j++)
      exp_t[j] = f_max(exp_t[j-1] + f_states(c), hw + 1);
    last = exp_t[len];
    @(negedge clk_i);
    area_sel_i  = AREA_W'(sel);
    burst_len_i = LEN_W'(len);
    start_i     = 1'b1;
    wait_i      = (hw > 0);
    idx = 0;
    for (n = 1; n <= last + 6; n++) begin
      @(negedge clk_i);
      start_i = 1'b0;
      wait_i  = (n < hw);
      if (inject && n == 1) begin
        start_i     = 1'b1;
        area_sel_i  = ~area_sel_i;
        burst_len_i = ~burst_len_i;
      end
      if (ready_o) begin
        if (idx <= len) check(n == exp_t[idx], req, n, exp_t[idx]);
        else check(1'b0, "R8 extra ready", n, 0);
        idx++;
      end
      if (done_o) check(n == last, "R8 done edge", n, last);
      if (n == last) check(done_o == 1'b1, "R8 done with last ready", int'(done_o), 1);
    end
    start_i = 1'b0;
    wait_i  = 1'b0;
    check(idx == len + 1, "R8 ready count", idx, len + 1);
    check(busy_o == 1'b0, "R8 idle after access", int'(busy_o), 0);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    #1;
    check({ready_o, done_o, busy_o} == 3'b000, "R10 in reset",
          int'({ready_o, done_o, busy_o}), 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check({ready_o, done_o, busy_o} == 3'b000, "R10 after reset",
          int'({ready_o, done_o, busy_o}), 0);

    // R1: every code in the top transfer, WAIT low, card mode on
    area_card_i = '1;
    for (int c = 0; c < 16; c++) begin
      area_code_i[3:0] = 4'(c);
      run_xfer(0, 0, 0, 1'b0, "R1 top waits");
    end
    // R4: every code with two beats
    for (int c = 0; c < 16; c++) begin
      area_code_i[3:0] = 4'(c);
      run_xfer(0, 2, 0, 1'b0, "R4 beat states");
    end
    // R2: code 0 ignores WAIT in top; R5: beat still stretched
    area_code_i[3:0] = 4'd0;
    run_xfer(0, 0, 9, 1'b0, "R2 code0 top ignores wait");
    run_xfer(0, 1, 9, 1'b0, "R5 code0 beat honours wait");
    // R3: nonzero code stretched past its count
    area_code_i[3:0] = 4'd3;
    run_xfer(0, 0, 12, 1'b0, "R3 top honours wait");
    run_xfer(0, 0, 4, 1'b0, "R3 wait inside count");
    area_code_i[3:0] = 4'd7;
    run_xfer(0, 3, 30, 1'b0, "R5 beats honour wait");
    // R7: high bit gated by card mode, area 1
    area_code_i = 8'hF2;
    area_card_i = 2'b00;
    run_xfer(1, 1, 0, 1'b0, "R7 high bit ignored");
    area_card_i = 2'b10;
    run_xfer(1, 1, 0, 1'b0, "R7 high bit in card mode");
    // R6: per-area codes, select changed mid access; R9: start ignored
    area_code_i = 8'h5C;
    area_card_i = 2'b11;
    run_xfer(0, 2, 0, 1'b1, "R6 area0 captured");
    run_xfer(1, 3, 0, 1'b1, "R9 busy start ignored");
    area_code_i = 8'h10;
    run_xfer(1, 0, 0, 1'b1, "R9 short access disturbed");

    // random mix
    for (int t = 0; t < 60; t++) begin
      area_code_i = 8'($urandom);
      area_card_i = 2'($urandom);
      run_xfer(int'($urandom_range(0, 1)), int'($urandom_range(0, 4)),
               ($urandom_range(0, 1) == 1) ? int'($urandom_range(0, 45)) : 0,
               1'($urandom), "R3 R5 random access");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule